// File: doc/BRIEF.md
# Instruction Dispatch Router

The router sits between the rename stage and the scheduling structures of an out-of-order core. Each cycle it receives a group of up to `SLOTS` renamed instructions. Each instruction carries a class code and a squashed flag. The router walks the group from slot 0 upward and decides, for every instruction, which destinations receive it:

- the issue queue,
- the load/store queue,
- the non-speculative issue path,
- a direct-complete path that only moves the queue tail forward.

It also decides which status marks the instruction receives.

The router knows how many issue-queue entries are free. If the queue runs out part-way through a group, it stops at that slot, discards the rest of the group and raises both a block flag and an upstream stall for that cycle. The issue queue and load/store queue themselves are outside the block. All per-slot strobes and flags are registered and appear in the cycle after the group is presented. Free-running counters report activity per class.

Top module: `dispatch_router`

## Requirements
- R1: Slots are examined in ascending order starting at slot 0. A slot whose index is not below `grpSize` produces no strobe and no status mark, and changes no counter.
- R2: A slot with its squashed flag set is dropped. It raises no strobe or mark, consumes no issue-queue entry, increments `cntSquashed` by one, and is dropped even when the queue has no free entry.
- R3: A non-squashed slot for which no issue-queue entry remains causes the following, all in the output cycle: `blockOut` and `stallOut` are both 1, `cntFullEvt` increments by exactly one, and that slot and every later slot of the group receive nothing.
- R4: Class code 0 (normal) sets only that slot's bit of `iqInsEn` and increments `cntDispatched`. Codes 5 to 7 behave as code 0.
- R5: Class code 1 (load) sets both `iqInsEn` and `lsqLoadEn` for the slot, and increments both `cntDispatched` and `cntLoad`.
- R6: Class code 2 (store) sets `lsqStoreEn`, `nonSpecEn` and `setCanCommit` for the slot, with no `iqInsEn`. It increments both `cntStore` and `cntNonSpec`.
- R7: Class code 3 (non-speculative) sets only `nonSpecEn` and `setCanCommit` for the slot, and increments `cntNonSpec`.
- R8: Class code 4 (nop) sets `tailAdvEn`, `setIssued`, `setExecuted` and `setCanCommit` for the slot and no other strobe.
- R9: Every non-squashed instruction that is routed consumes one issue-queue entry, whatever its class. The number routed in a group never exceeds `iqFree`.
- R10: Bit i of every per-slot output belongs to slot i. Outputs are registered: they reflect the group presented at the previous rising clock edge, so a cycle with `grpSize` = 0 gives all strobes and `blockOut` at 0.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpSize | input | $clog2(SLOTS+1) | Number of valid slots in the group |
| slotClass | input | 3*SLOTS | Class code per slot, slot i in bits [3i+2:3i] |
| slotSquashed | input | SLOTS | Squashed flag per slot |
| iqFree | input | $clog2(IQ_DEPTH+1) | Free issue-queue entries |
| iqInsEn | output | SLOTS | Normal issue-queue insert strobe |
| lsqLoadEn | output | SLOTS | Load reservation strobe |
| lsqStoreEn | output | SLOTS | Store insert strobe |
| nonSpecEn | output | SLOTS | Non-speculative path strobe |
| tailAdvEn | output | SLOTS | Direct-complete tail advance strobe |
| setIssued | output | SLOTS | Mark instruction issued |
| setExecuted | output | SLOTS | Mark instruction executed |
| setCanCommit | output | SLOTS | Mark instruction ready to commit |
| blockOut | output | 1 | Stage blocked on full issue queue |
| stallOut | output | 1 | Stall request to the upstream stage |
| cntDispatched | output | CNT_W | Normal issue-queue inserts |
| cntLoad | output | CNT_W | Loads routed |
| cntStore | output | CNT_W | Stores routed |
| cntNonSpec | output | CNT_W | Instructions sent to the non-speculative path |
| cntSquashed | output | CNT_W | Squashed instructions dropped |
| cntFullEvt | output | CNT_W | Full-queue events |

## Verification
The bench builds the router with `SLOTS` = 4 and `IQ_DEPTH` = 8, so a full group fits in four readable bits. Setting `iqFree` below the group size truncates the group at any slot, including slot 0. `CNT_W` = 16 keeps every counter far from wrapping, so each one can be compared exactly with a running total in the bench. Groups mix all five class codes with squashed slots. They also place squashed slots both before and after the point where the queue fills.

// File: rtl/dispatch_router_pkg.sv
package dispatch_router_pkg;

  typedef enum logic [2:0] {
    CLS_NORMAL = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_NONSPEC = 3'd3,
    CLS_NOP    = 3'd4
  } instClass_e;

  // per-slot routing decision passed from control to datapath
  typedef struct packed {
    logic drop;
    logic toIq;
    logic toLd;
    logic toSt;
    logic toNs;
    logic toNop;
  } slotRoute_t;

endpackage

// File: rtl/dispatch_router_ctrl.sv
module dispatch_router_ctrl
  import dispatch_router_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IQ_DEPTH = 16,
  localparam int SZ_W = $clog2(SLOTS + 1),
  localparam int FREE_W = $clog2(IQ_DEPTH + 1)
) (
  input  logic [SZ_W-1:0]    grpSize,
  input  logic [3*SLOTS-1:0] slotClass,
  input  logic [SLOTS-1:0]   slotSquashed,
  input  logic [FREE_W-1:0]  iqFree,
  output slotRoute_t         route [SLOTS],
  output logic               fullHit
);

  logic [2:0] clsOf [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_cls
      assign clsOf[g] = slotClass[3*g +: 3];
    end
  endgenerate

  always_comb begin
    logic [FREE_W-1:0] usedCnt;
    logic stopped;
    usedCnt = '0;
    stopped = 1'b0;
    fullHit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      route[i] = '0;
      if (!stopped && (SZ_W'(i) < grpSize)) begin
        if (slotSquashed[i]) begin
          route[i].drop = 1'b1;
        end else if (usedCnt >= iqFree) begin
          fullHit = 1'b1;
          stopped = 1'b1;
        end else begin
          usedCnt = usedCnt + 1'b1;
          case (clsOf[i])
            CLS_LOAD: begin
              route[i].toIq = 1'b1;
              route[i].toLd = 1'b1;
            end
            CLS_STORE: begin
              route[i].toSt = 1'b1;
              route[i].toNs = 1'b1;
            end
            CLS_NONSPEC: route[i].toNs = 1'b1;
            CLS_NOP:     route[i].toNop = 1'b1;
            default:     route[i].toIq = 1'b1;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dispatch_router_dp.sv
module dispatch_router_dp
  import dispatch_router_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = 16,
  localparam int INC_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotRoute_t       route [SLOTS],
  input  logic             fullHit,
  output logic [SLOTS-1:0] iqInsEn,
  output logic [SLOTS-1:0] lsqLoadEn,
  output logic [SLOTS-1:0] lsqStoreEn,
  output logic [SLOTS-1:0] nonSpecEn,
  output logic [SLOTS-1:0] tailAdvEn,
  output logic [SLOTS-1:0] setIssued,
  output logic [SLOTS-1:0] setExecuted,
  output logic [SLOTS-1:0] setCanCommit,
  output logic             blockOut,
  output logic             stallOut,
  output logic [CNT_W-1:0] cntDispatched,
  output logic [CNT_W-1:0] cntLoad,
  output logic [CNT_W-1:0] cntStore,
  output logic [CNT_W-1:0] cntNonSpec,
  output logic [CNT_W-1:0] cntSquashed,
  output logic [CNT_W-1:0] cntFullEvt
);

  logic [SLOTS-1:0] nIq, nLd, nSt, nNs, nNop, nDrop;
  logic [INC_W-1:0] incIq, incLd, incSt, incNs, incDrop;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_unpack
      assign nIq[g]   = route[g].toIq;
      assign nLd[g]   = route[g].toLd;
      assign nSt[g]   = route[g].toSt;
      assign nNs[g]   = route[g].toNs;
      assign nNop[g]  = route[g].toNop;
      assign nDrop[g] = route[g].drop;
    end
  endgenerate

  always_comb begin
    incIq = '0; incLd = '0; incSt = '0; incNs = '0; incDrop = '0;
    for (int i = 0; i < SLOTS; i++) begin
      incIq   = incIq   + INC_W'(nIq[i]);
      incLd   = incLd   + INC_W'(nLd[i]);
      incSt   = incSt   + INC_W'(nSt[i]);
      incNs   = incNs   + INC_W'(nNs[i]);
      incDrop = incDrop + INC_W'(nDrop[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iqInsEn <= '0; lsqLoadEn <= '0; lsqStoreEn <= '0; nonSpecEn <= '0;
      tailAdvEn <= '0; setIssued <= '0; setExecuted <= '0; setCanCommit <= '0;
      blockOut <= 1'b0; stallOut <= 1'b0;
      cntDispatched <= '0; cntLoad <= '0; cntStore <= '0;
      cntNonSpec <= '0; cntSquashed <= '0; cntFullEvt <= '0;
    end else begin
      iqInsEn      <= nIq;
      lsqLoadEn    <= nLd;
      lsqStoreEn   <= nSt;
      nonSpecEn    <= nNs;
      tailAdvEn    <= nNop;
      setIssued    <= nNop;
      setExecuted  <= nNop;
      setCanCommit <= nNs | nNop;
      blockOut     <= fullHit;
      stallOut     <= fullHit;
      cntDispatched <= cntDispatched + CNT_W'(incIq);
      cntLoad       <= cntLoad + CNT_W'(incLd);
      cntStore      <= cntStore + CNT_W'(incSt);
      cntNonSpec    <= cntNonSpec + CNT_W'(incNs);
      cntSquashed   <= cntSquashed + CNT_W'(incDrop);
      cntFullEvt    <= cntFullEvt + CNT_W'(fullHit);
    end
  end

endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
  import dispatch_router_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IQ_DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int SZ_W = $clog2(SLOTS + 1),
  localparam int FREE_W = $clog2(IQ_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SZ_W-1:0]    grpSize,
  input  logic [3*SLOTS-1:0] slotClass,
  input  logic [SLOTS-1:0]   slotSquashed,
  input  logic [FREE_W-1:0]  iqFree,
  output logic [SLOTS-1:0]   iqInsEn,
  output logic [SLOTS-1:0]   lsqLoadEn,
  output logic [SLOTS-1:0]   lsqStoreEn,
  output logic [SLOTS-1:0]   nonSpecEn,
  output logic [SLOTS-1:0]   tailAdvEn,
  output logic [SLOTS-1:0]   setIssued,
  output logic [SLOTS-1:0]   setExecuted,
  output logic [SLOTS-1:0]   setCanCommit,
  output logic               blockOut,
  output logic               stallOut,
  output logic [CNT_W-1:0]   cntDispatched,
  output logic [CNT_W-1:0]   cntLoad,
  output logic [CNT_W-1:0]   cntStore,
  output logic [CNT_W-1:0]   cntNonSpec,
  output logic [CNT_W-1:0]   cntSquashed,
  output logic [CNT_W-1:0]   cntFullEvt
);

  slotRoute_t route [SLOTS];
  logic fullHit;

  dispatch_router_ctrl #(.SLOTS(SLOTS), .IQ_DEPTH(IQ_DEPTH)) u_ctrl (
    .grpSize(grpSize), .slotClass(slotClass), .slotSquashed(slotSquashed),
    .iqFree(iqFree), .route(route), .fullHit(fullHit)
  );

  dispatch_router_dp #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .route(route), .fullHit(fullHit),
    .iqInsEn(iqInsEn), .lsqLoadEn(lsqLoadEn), .lsqStoreEn(lsqStoreEn),
    .nonSpecEn(nonSpecEn), .tailAdvEn(tailAdvEn), .setIssued(setIssued),
    .setExecuted(setExecuted), .setCanCommit(setCanCommit),
    .blockOut(blockOut), .stallOut(stallOut),
    .cntDispatched(cntDispatched), .cntLoad(cntLoad), .cntStore(cntStore),
    .cntNonSpec(cntNonSpec), .cntSquashed(cntSquashed), .cntFullEvt(cntFullEvt)
  );

endmodule

// File: rtl/dispatch_router_chk.sv
module dispatch_router_chk #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [SLOTS-1:0] iqInsEn,
  input logic [SLOTS-1:0] lsqLoadEn,
  input logic [SLOTS-1:0] lsqStoreEn,
  input logic [SLOTS-1:0] nonSpecEn,
  input logic [SLOTS-1:0] tailAdvEn,
  input logic [SLOTS-1:0] setExecuted,
  input logic [SLOTS-1:0] setCanCommit,
  input logic             blockOut,
  input logic             stallOut,
  input logic [CNT_W-1:0] cntFullEvt,
  input logic [CNT_W-1:0] cntStore,
  input logic [CNT_W-1:0] cntNonSpec
);

  // R3
  block_stall_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockOut == stallOut);

  // R3
  full_event_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockOut |-> cntFullEvt == $past(cntFullEvt) + 1'b1);

  // R5
  load_needs_iq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsqLoadEn & ~iqInsEn) == '0);

  // R6
  store_not_in_iq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsqStoreEn & (iqInsEn | ~nonSpecEn | ~setCanCommit)) == '0);

  // R6
  store_counts_nonspec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntStore - $past(cntStore)) <= (cntNonSpec - $past(cntNonSpec)));

  // R8
  nop_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tailAdvEn & (iqInsEn | nonSpecEn | lsqLoadEn | ~setExecuted)) == '0);

endmodule

bind dispatch_router dispatch_router_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .iqInsEn(iqInsEn), .lsqLoadEn(lsqLoadEn),
  .lsqStoreEn(lsqStoreEn), .nonSpecEn(nonSpecEn), .tailAdvEn(tailAdvEn),
  .setExecuted(setExecuted), .setCanCommit(setCanCommit),
  .blockOut(blockOut), .stallOut(stallOut), .cntFullEvt(cntFullEvt),
  .cntStore(cntStore), .cntNonSpec(cntNonSpec)
);

// File: tb/dispatch_router_bench.sv
module dispatch_router_bench;
  localparam int SLOTS = 4;
  localparam int IQ_DEPTH = 8;
  localparam int CNT_W = 16;
  localparam int SZ_W = $clog2(SLOTS + 1);
  localparam int FREE_W = $clog2(IQ_DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SZ_W-1:0] grpSize = '0;
  logic [3*SLOTS-1:0] slotClass = '0;
  logic [SLOTS-1:0] slotSquashed = '0;
  logic [FREE_W-1:0] iqFree = '0;
  logic [SLOTS-1:0] iqInsEn, lsqLoadEn, lsqStoreEn, nonSpecEn, tailAdvEn;
  logic [SLOTS-1:0] setIssued, setExecuted, setCanCommit;
  logic blockOut, stallOut;
  logic [CNT_W-1:0] cntDispatched, cntLoad, cntStore, cntNonSpec, cntSquashed, cntFullEvt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected running counters
  int eDisp = 0, eLd = 0, eSt = 0, eNs = 0, eSq = 0, eFull = 0;

  always #2 clk = ~clk;

  dispatch_router #(.SLOTS(SLOTS), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) u_dispatch_router (
    .clk(clk), .rstN(rstN), .grpSize(grpSize), .slotClass(slotClass),
    .slotSquashed(slotSquashed), .iqFree(iqFree), .iqInsEn(iqInsEn),
    .lsqLoadEn(lsqLoadEn), .lsqStoreEn(lsqStoreEn), .nonSpecEn(nonSpecEn),
    .tailAdvEn(tailAdvEn), .setIssued(setIssued), .setExecuted(setExecuted),
    .setCanCommit(setCanCommit), .blockOut(blockOut), .stallOut(stallOut),
    .cntDispatched(cntDispatched), .cntLoad(cntLoad), .cntStore(cntStore),
    .cntNonSpec(cntNonSpec), .cntSquashed(cntSquashed), .cntFullEvt(cntFullEvt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chkVal(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Present a group, apply it for one edge, compare against the model.
  task automatic runGroup(input string tag, input int size, input int cls [SLOTS],
                          input logic [SLOTS-1:0] sq, input int free);
    logic [SLOTS-1:0] xIq, xLd, xSt, xNs, xNop;
    bit xBlk, stop;
    int used;
    xIq = '0; xLd = '0; xSt = '0; xNs = '0; xNop = '0; xBlk = 0; stop = 0; used = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop && i < size) begin
        if (sq[i]) eSq++;
        else if (used >= free) begin xBlk = 1; stop = 1; eFull++; end
        else begin
          used++;
          case (cls[i])
            1: begin xIq[i] = 1; xLd[i] = 1; eDisp++; eLd++; end
            2: begin xSt[i] = 1; xNs[i] = 1; eSt++; eNs++; end
            3: begin xNs[i] = 1; eNs++; end
            4: xNop[i] = 1;
            default: begin xIq[i] = 1; eDisp++; end
          endcase
        end
      end
    end
    @(negedge clk);
    grpSize = SZ_W'(size);
    for (int i = 0; i < SLOTS; i++) slotClass[3*i +: 3] = 3'(cls[i]);
    slotSquashed = sq;
    iqFree = FREE_W'(free);
    @(negedge clk);
    grpSize = '0;
    chkVal({tag, " R4 iqInsEn"}, int'(iqInsEn), int'(xIq));
    chkVal({tag, " R5 lsqLoadEn"}, int'(lsqLoadEn), int'(xLd));
    chkVal({tag, " R6 lsqStoreEn"}, int'(lsqStoreEn), int'(xSt));
    chkVal({tag, " R7 nonSpecEn"}, int'(nonSpecEn), int'(xNs));
    chkVal({tag, " R8 tailAdvEn"}, int'(tailAdvEn), int'(xNop));
    chkVal({tag, " R8 setIssued"}, int'(setIssued), int'(xNop));
    chkVal({tag, " R8 setExecuted"}, int'(setExecuted), int'(xNop));
    chkVal({tag, " R6 setCanCommit"}, int'(setCanCommit), int'(xNs | xNop));
    chkVal({tag, " R3 blockOut"}, int'(blockOut), int'(xBlk));
    chkVal({tag, " R3 stallOut"}, int'(stallOut), int'(xBlk));
    chkVal({tag, " R4 cntDispatched"}, int'(cntDispatched), eDisp);
    chkVal({tag, " R5 cntLoad"}, int'(cntLoad), eLd);
    chkVal({tag, " R6 cntStore"}, int'(cntStore), eSt);
    chkVal({tag, " R7 cntNonSpec"}, int'(cntNonSpec), eNs);
    chkVal({tag, " R2 cntSquashed"}, int'(cntSquashed), eSq);
    chkVal({tag, " R3 cntFullEvt"}, int'(cntFullEvt), eFull);
  endtask

  task automatic testReset();
    chkVal("R11 strobes in reset", int'(iqInsEn | lsqLoadEn | lsqStoreEn | nonSpecEn | tailAdvEn), 0);
    chkVal("R11 marks in reset", int'(setIssued | setExecuted | setCanCommit), 0);
    chkVal("R11 block in reset", int'(blockOut | stallOut), 0);
    chkVal("R11 counters in reset", int'(cntDispatched | cntLoad | cntStore | cntNonSpec | cntSquashed | cntFullEvt), 0);
  endtask

  task automatic testNormals();   // R4, R10
    runGroup("normals", 4, '{0, 0, 0, 0}, 4'b0000, 8);
    runGroup("high codes", 4, '{5, 6, 7, 0}, 4'b0000, 8);
  endtask

  task automatic testMixed();     // R5, R6, R7, R10
    runGroup("mixed", 4, '{0, 1, 2, 3}, 4'b0000, 8);
    runGroup("mixed rev", 4, '{3, 2, 1, 4}, 4'b0000, 8);
  endtask

  task automatic testNopSquash(); // R2, R8
    runGroup("nop+sq", 4, '{4, 1, 4, 2}, 4'b0010, 8);
  endtask

  task automatic testTruncate();  // R3, R9
    runGroup("trunc2", 4, '{0, 1, 0, 0}, 4'b0000, 2);
    runGroup("trunc nop", 4, '{4, 3, 2, 1}, 4'b0000, 3);
    runGroup("full slot0", 4, '{1, 0, 0, 0}, 4'b0000, 0);
  endtask

  task automatic testSquashAtFull(); // R2, R3
    runGroup("sq at full", 3, '{0, 0, 0, 0}, 4'b0011, 0);
    runGroup("sq then full", 4, '{0, 0, 0, 0}, 4'b0101, 0);
    runGroup("sq after stop", 4, '{0, 0, 0, 0}, 4'b1000, 1);
  endtask

  task automatic testSizeLimit(); // R1, R10
    runGroup("size2", 2, '{2, 1, 3, 4}, 4'b0000, 8);
    runGroup("size0", 0, '{1, 2, 3, 4}, 4'b1111, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testNormals();
    testMixed();
    testNopSquash();
    testTruncate();
    testSquashAtFull();
    testSizeLimit();
    @(negedge clk);
    chkVal("R10 idle cycle block", int'(blockOut), 0);
    chkVal("R10 idle cycle strobes", int'(iqInsEn | nonSpecEn | tailAdvEn), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule